// File: doc/BRIEF.md
# Maskable Numeric Exception Controller

This block sits beside an arithmetic datapath and decides what happens when that datapath reports a numeric exception. It holds a 16-bit control word, which carries one mask bit for each of six exception kinds, and a status word, which carries six sticky exception flags and an error-summary bit. Each cycle the datapath may raise any mix of six event strobes: invalid operation, denormal operand, zero divide, overflow, underflow and precision. The first three are raised before an operation executes and the last three after it, but the controller treats them the same way.

A masked event is absorbed. The `use_default` output tells the datapath, in the same cycle, to substitute its default result (for example, infinity for a masked zero divide) and carry on. An unmasked event is not reported at once. It sets a pending fault, which is raised as a one-cycle `fault_taken` pulse when the next numeric instruction starts or when a wait is requested. An init command restores the power-on control word 037Fh, which masks all six kinds, and clears all flags. A clear-flags command empties the flags and the pending fault. All pins are plain control and status levels or strobes; there is no streamed data and no back-pressure.

Top module: `numeric_fault_ctrl`

## Requirements
- R1: After reset, `ctrl_word` is 16'h037F, `status_word` is 0 and `fault_pending` is 0.
- R2: When `cw_we` is high and `init_cmd` is low, all 16 bits of `cw_wdata` appear on `ctrl_word` after the next clock edge. This includes the rounding field in bits 11:10.
- R3: `init_cmd` loads `ctrl_word` with 16'h037F and clears the status flags and the pending fault after the next edge. It takes priority over a write in the same cycle.
- R4: An event strobe sets its status flag after the next edge. Bit positions are invalid=0, denormal=1, zero-divide=2, overflow=3, underflow=4, precision=5, and the mask bits in `ctrl_word` use the same positions. Flags are sticky: they accumulate across events.
- R5: `use_default` is high in the same cycle as an event strobe exactly when at least one strobed kind has its mask bit set.
- R6: An event with its mask bit clear raises `fault_pending` after the next edge. `fault_taken` does not go high in the event's own cycle unless a fault was already pending.
- R7: `fault_taken` is high exactly in a cycle where `fault_pending` is high and `insn_start` or `wait_req` is high. The pending fault is then cleared after that edge, unless a new unmasked event arrives in the same cycle, in which case it stays pending.
- R8: Status bit 7 is high whenever some flag is set whose mask bit is clear. Status bits 6 and 15:8 always read 0.
- R9: `clr_flags` clears the flags and the pending fault. An event in the same cycle wins, and its flag is set.
- R10: An event whose every strobed kind is masked never sets `fault_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_pulse | input | 6 | Exception event strobes, one per kind |
| insn_start | input | 1 | A numeric instruction begins this cycle |
| wait_req | input | 1 | Explicit wait for pending faults |
| cw_we | input | 1 | Control-word write enable |
| cw_wdata | input | 16 | Control-word write data |
| init_cmd | input | 1 | Restore 037Fh and clear the flags |
| clr_flags | input | 1 | Clear the flags and the pending fault |
| ctrl_word | output | 16 | Current control word |
| status_word | output | 16 | Flags in bits 5:0, error summary in bit 7 |
| use_default | output | 1 | Substitute the default result for a masked event |
| fault_pending | output | 1 | An unmasked fault awaits reporting |
| fault_taken | output | 1 | Pending fault raised this cycle |

## Verification
Two pairs of functions can land in the same cycle. An instruction start may consume an old pending fault while that instruction's own unmasked event arrives. A clear-flags command may meet a fresh event. The bench drives each pair of strobes on the same clock. For the first pair it expects `fault_taken` to pulse while `fault_pending` stays high. For the second it expects the new flag to survive the clear. A full sweep over all 64 masks and all 64 event patterns then checks the default-result decision, the flags, the summary bit and the deferred fault.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int NUM_EXC = 6;
  localparam int CW_W    = 16;
  localparam logic [CW_W-1:0] CW_INIT = 16'h037F;
  localparam int SUM_BIT = 7;

  typedef enum int {
    EXC_INVALID = 0,
    EXC_DENORM  = 1,
    EXC_ZDIV    = 2,
    EXC_OVF     = 3,
    EXC_UNF     = 4,
    EXC_PREC    = 5
  } exc_idx_e;
endpackage

// File: rtl/nfc_ctrl_word.sv
module nfc_ctrl_word #(
  parameter int CW_W = nfc_pkg::CW_W,
  parameter logic [CW_W-1:0] CW_INIT = nfc_pkg::CW_INIT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_cmd,
  input  logic            wr_en,
  input  logic [CW_W-1:0] wr_data,
  output logic [CW_W-1:0] cw_q
);
  logic [CW_W-1:0] cw_d;

  always_comb begin
    cw_d = cw_q;
    if (init_cmd)   cw_d = CW_INIT;
    else if (wr_en) cw_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cw_q <= CW_INIT;
    else        cw_q <= cw_d;
  end
endmodule

// File: rtl/nfc_flag_bank.sv
module nfc_flag_bank #(
  parameter int NUM_EXC = nfc_pkg::NUM_EXC,
  parameter int SW_W    = nfc_pkg::CW_W,
  parameter int SUM_BIT = nfc_pkg::SUM_BIT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_cmd,
  input  logic               clr_flags,
  input  logic [NUM_EXC-1:0] ev,
  input  logic [NUM_EXC-1:0] mask,
  output logic [NUM_EXC-1:0] flags_q,
  output logic [SW_W-1:0]    status,
  output logic               use_default
);
  logic [NUM_EXC-1:0] absorbed;

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_flag
    logic flag_d;
    always_comb begin
      if (init_cmd)       flag_d = 1'b0;
      else if (clr_flags) flag_d = ev[i];
      else                flag_d = flags_q[i] | ev[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flag_d;
    end
    assign absorbed[i] = ev[i] & mask[i];
  end

  assign use_default = |absorbed;

  always_comb begin
    status = '0;
    status[NUM_EXC-1:0] = flags_q;
    status[SUM_BIT] = |(flags_q & ~mask);
  end
endmodule

// File: rtl/nfc_fault_track.sv
module nfc_fault_track #(
  parameter int NUM_EXC = nfc_pkg::NUM_EXC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_cmd,
  input  logic               clr_flags,
  input  logic               insn_start,
  input  logic               wait_req,
  input  logic [NUM_EXC-1:0] ev,
  input  logic [NUM_EXC-1:0] mask,
  output logic               pend_q,
  output logic               taken
);
  logic raise;
  logic consume;
  logic pend_d;

  assign raise   = |(ev & ~mask);
  assign taken   = pend_q & (insn_start | wait_req);
  assign consume = taken | clr_flags;

  always_comb begin
    if (init_cmd) pend_d = 1'b0;
    else          pend_d = raise | (pend_q & ~consume);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/numeric_fault_ctrl.sv
module numeric_fault_ctrl #(
  parameter int NUM_EXC = nfc_pkg::NUM_EXC,
  parameter int CW_W    = nfc_pkg::CW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXC-1:0] ev_pulse,
  input  logic               insn_start,
  input  logic               wait_req,
  input  logic               cw_we,
  input  logic [CW_W-1:0]    cw_wdata,
  input  logic               init_cmd,
  input  logic               clr_flags,
  output logic [CW_W-1:0]    ctrl_word,
  output logic [CW_W-1:0]    status_word,
  output logic               use_default,
  output logic               fault_pending,
  output logic               fault_taken
);
  logic [NUM_EXC-1:0] mask;
  logic [NUM_EXC-1:0] flags;

  nfc_ctrl_word #(.CW_W(CW_W)) u_cw (
    .clk(clk), .rst_n(rst_n), .init_cmd(init_cmd),
    .wr_en(cw_we), .wr_data(cw_wdata), .cw_q(ctrl_word)
  );

  assign mask = ctrl_word[NUM_EXC-1:0];

  nfc_flag_bank #(.NUM_EXC(NUM_EXC), .SW_W(CW_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .init_cmd(init_cmd), .clr_flags(clr_flags),
    .ev(ev_pulse), .mask(mask), .flags_q(flags), .status(status_word),
    .use_default(use_default)
  );

  nfc_fault_track #(.NUM_EXC(NUM_EXC)) u_fault (
    .clk(clk), .rst_n(rst_n), .init_cmd(init_cmd), .clr_flags(clr_flags),
    .insn_start(insn_start), .wait_req(wait_req), .ev(ev_pulse), .mask(mask),
    .pend_q(fault_pending), .taken(fault_taken)
  );
endmodule

// File: rtl/nfc_checker.sv
module nfc_checker #(
  parameter int NUM_EXC = 6,
  parameter int CW_W    = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EXC-1:0] ev_pulse,
  input logic               insn_start,
  input logic               wait_req,
  input logic               cw_we,
  input logic [CW_W-1:0]    cw_wdata,
  input logic               init_cmd,
  input logic               clr_flags,
  input logic [CW_W-1:0]    ctrl_word,
  input logic [CW_W-1:0]    status_word,
  input logic               use_default,
  input logic               fault_pending,
  input logic               fault_taken
);
  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_we && !init_cmd) |=> ctrl_word == $past(cw_wdata));

  p_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init_cmd |=> (ctrl_word == 16'h037F && status_word == '0 && !fault_pending));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_cmd && !clr_flags) |=>
      ((status_word[NUM_EXC-1:0] & $past(status_word[NUM_EXC-1:0])) == $past(status_word[NUM_EXC-1:0])));

  p_event_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !init_cmd |=> ((status_word[NUM_EXC-1:0] & $past(ev_pulse)) == $past(ev_pulse)));

  p_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
    use_default |-> ev_pulse != '0);

  p_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_cmd && (ev_pulse & ~ctrl_word[NUM_EXC-1:0]) != '0) |=> fault_pending);

  p_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_taken |-> (fault_pending && (insn_start || wait_req)));

  p_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_pending && (ev_pulse & ~ctrl_word[NUM_EXC-1:0]) == '0) |=> !fault_pending);
endmodule

bind numeric_fault_ctrl nfc_checker #(.NUM_EXC(NUM_EXC), .CW_W(CW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .insn_start(insn_start),
  .wait_req(wait_req), .cw_we(cw_we), .cw_wdata(cw_wdata), .init_cmd(init_cmd),
  .clr_flags(clr_flags), .ctrl_word(ctrl_word), .status_word(status_word),
  .use_default(use_default), .fault_pending(fault_pending), .fault_taken(fault_taken)
);

// File: tb/numeric_fault_ctrl_bench.sv
`timescale 1ns/1ps
module numeric_fault_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ev_pulse = '0;
  logic        insn_start = 1'b0, wait_req = 1'b0, cw_we = 1'b0;
  logic [15:0] cw_wdata = '0;
  logic        init_cmd = 1'b0, clr_flags = 1'b0;
  logic [15:0] ctrl_word, status_word;
  logic        use_default, fault_pending, fault_taken;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  numeric_fault_ctrl u_numeric_fault_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .insn_start(insn_start),
    .wait_req(wait_req), .cw_we(cw_we), .cw_wdata(cw_wdata), .init_cmd(init_cmd),
    .clr_flags(clr_flags), .ctrl_word(ctrl_word), .status_word(status_word),
    .use_default(use_default), .fault_pending(fault_pending), .fault_taken(fault_taken)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic idle();
    ev_pulse = '0; insn_start = 0; wait_req = 0; cw_we = 0;
    init_cmd = 0; clr_flags = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) nxt();
    // R1 reset state
    chk("R1 ctrl", ctrl_word, 16'h037F);
    chk("R1 status", status_word, 16'h0000);
    chk("R1 pending", {15'd0, fault_pending}, 16'd1 & 16'd0);
    rst_n = 1'b1;
    nxt();

    // R2 full write, then R3 init overrides a same-cycle write
    cw_we = 1; cw_wdata = 16'hABC0; nxt(); idle();
    chk("R2 write", ctrl_word, 16'hABC0);
    ev_pulse = 6'b000100; nxt(); idle();
    chk("R6 zdiv pending", {15'd0, fault_pending}, 16'd1);
    init_cmd = 1; cw_we = 1; cw_wdata = 16'h1234; nxt(); idle();
    chk("R3 init ctrl", ctrl_word, 16'h037F);
    chk("R3 init status", status_word, 16'h0000);
    chk("R3 init pending", {15'd0, fault_pending}, 16'd0);

    // R4 sticky accumulation under all-masked control
    ev_pulse = 6'b000001; nxt(); idle();
    ev_pulse = 6'b100000; nxt(); idle();
    chk("R4 sticky", status_word, 16'h0021);
    chk("R10 masked no pend", {15'd0, fault_pending}, 16'd0);
    clr_flags = 1; nxt(); idle();

    // Collision: start consuming old fault while new unmasked event arrives (R7)
    cw_we = 1; cw_wdata = 16'h0000; nxt(); idle();
    ev_pulse = 6'b001000; nxt(); idle();
    ev_pulse = 6'b010000; insn_start = 1;
    #1 chk("R7 taken on collision", {15'd0, fault_taken}, 16'd1);
    nxt(); idle();
    chk("R7 stays pending", {15'd0, fault_pending}, 16'd1);
    wait_req = 1; #1 chk("R7 wait takes", {15'd0, fault_taken}, 16'd1);
    nxt(); idle();
    chk("R7 cleared", {15'd0, fault_pending}, 16'd0);
    // Collision: clear with a fresh event (R9)
    clr_flags = 1; ev_pulse = 6'b000010; nxt(); idle();
    chk("R9 event wins flag", status_word[5:0], 16'h0002);
    chk("R9 event wins pend", {15'd0, fault_pending}, 16'd1);
    clr_flags = 1; nxt(); idle();
    chk("R9 clear", status_word, 16'h0000);
    chk("R9 clear pend", {15'd0, fault_pending}, 16'd0);

    // Sweep all masks and event patterns
    for (int m = 0; m < 64; m++) begin
      cw_we = 1; cw_wdata = 16'h0C40 | 16'(m); nxt(); idle();
      chk("R2 sweep write", ctrl_word, 16'h0C40 | 16'(m));
      for (int e = 0; e < 64; e++) begin
        logic unm;
        unm = |(6'(e) & ~6'(m));
        ev_pulse = 6'(e);
        #1 chk("R5 use_default", {15'd0, use_default}, {15'd0, |(6'(e) & 6'(m))});
        chk("R6 not immediate", {15'd0, fault_taken}, 16'd0);
        nxt(); idle();
        chk("R4 flags", status_word[5:0], 16'(e));
        chk("R8 summary", {15'd0, status_word[7]}, {15'd0, unm});
        chk("R8 reserved", {status_word[15:8], 1'b0, status_word[6], 6'd0}, 16'd0);
        chk("R6 R10 pending", {15'd0, fault_pending}, {15'd0, unm});
        if (e[0]) insn_start = 1; else wait_req = 1;
        #1 chk("R7 taken", {15'd0, fault_taken}, {15'd0, unm});
        nxt(); idle();
        chk("R7 consumed", {15'd0, fault_pending}, 16'd0);
        clr_flags = 1; nxt(); idle();
        chk("R9 sweep clear", status_word, 16'h0000);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule